// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial frames on a single output line. It keeps two registers. Software writes a holding register, and a separate shift register drives the line. A data-empty flag coordinates the two. A write clears the flag. The transmitter then moves the holding register into the shift register on the next bit slot and sets the flag again, so software can queue the following byte while the current one is still being sent.

Each frame has the following fields:
- A start bit.
- Seven or eight data bits, sent least significant bit first.
- An optional extra bit, which is either parity or a multiprocessor marker.
- One or two stop bits.

When a byte is already waiting as the last stop bit ends, the next frame follows with no idle gap. Otherwise a transmit-end flag is raised during the final stop bit, and the line then rests at 1. Two level interrupt requests follow the flags, each behind its own enable.

Every serial bit lasts exactly one pulse of `baudTick`. An external divider supplies this pulse. The block does not generate the baud rate, does not receive, and has no synchronous mode.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, and at any time while idle, `txLine` is 1, `dataEmpty` is 1 and `txEnd` is 1.
- R2: A write (`wrEn` high while `txEnable` is 1) clears `dataEmpty` and `txEnd` on the next clock. On the next `baudTick`, the byte moves to the shift register and `dataEmpty` returns to 1.
- R3: Each frame starts with one start bit of value 0 that lasts exactly one `baudTick` period.
- R4: Data bits follow the start bit, least significant bit first. There are 8 of them when `shortWord` is 0, and 7 when it is 1; in the 7-bit case, bit 7 of the written byte is never sent.
- R5: When `parityOn` is 1 and `mpMode` is 0, one parity bit follows the data. It is the XOR of the data bits that were sent, inverted when `parityOdd` is 1, so that even parity gives an even count of ones.
- R6: When `mpMode` is 1, the extra bit carries `mpBit` as sampled when the byte entered the shift register. This takes precedence over parity. When both `mpMode` and `parityOn` are 0, no extra bit is sent.
- R7: The frame ends with one stop bit of value 1, or two when `twoStop` is 1. All format inputs are captured when the byte is loaded.
- R8: If `dataEmpty` is 0 when the last stop bit ends, the waiting byte is loaded and its start bit begins on the same `baudTick`.
- R9: If no byte is waiting when the final stop bit begins, `txEnd` rises in that bit. After the stop bit the line stays at 1.
- R10: `emptyIrq` equals `dataEmpty` AND `emptyIntEn`, and `endIrq` equals `txEnd` AND `endIntEn`.
- R11: While `txEnable` is 0, `txLine`, `dataEmpty` and `txEnd` read 1 and writes are ignored. A byte written while disabled is never sent after re-enabling.
- R12: The line and all state change only on clocks where `baudTick` is 1, apart from the flag updates that a write causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter enable |
| baudTick | input | 1 | One-cycle pulse per serial bit |
| wrEn | input | 1 | Holding register write strobe |
| wrData | input | 8 | Byte to write |
| shortWord | input | 1 | 1 selects 7 data bits |
| parityOn | input | 1 | Adds a parity bit |
| parityOdd | input | 1 | 1 selects odd parity |
| mpMode | input | 1 | Extra bit carries `mpBit` |
| mpBit | input | 1 | Multiprocessor bit value |
| twoStop | input | 1 | 1 selects two stop bits |
| emptyIntEn | input | 1 | Enable for the data-empty request |
| endIntEn | input | 1 | Enable for the transmit-end request |
| txLine | output | 1 | Serial output |
| dataEmpty | output | 1 | Holding register free |
| txEnd | output | 1 | Transmission finished, line idle |
| emptyIrq | output | 1 | Data-empty interrupt request |
| endIrq | output | 1 | Transmit-end interrupt request |

## Verification
Random bytes are sent under random combinations of word length, extra-bit kind, parity sense and stop count, with every bit slot compared against a frame built by a bench function. This separates errors in bit order, in field length and in parity sense. Directed cases cover the following:
- A chained pair, which shows the back-to-back start bit as distinct from the idle-with-end-flag path.
- A change of `mpBit` after the load, which shows whether the value is captured or merely followed.
- A write while disabled.
- A stretch with no tick, which shows that nothing moves between bit slots.

// File: rtl/dbuf_tx_pkg.sv
package dbuf_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP1,
    ST_STOP2
  } txState_e;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_EXTRA
  } lineSel_e;

  typedef struct packed {
    logic     holdWr;
    logic     loadShift;
    logic     shiftStep;
    lineSel_e lineSel;
  } txStrobe_t;

endpackage

// File: rtl/dbuf_tx_dpath.sv
module dbuf_tx_dpath
  import dbuf_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              shortWord,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              mpMode,
  input  logic              mpBit,
  input  logic              twoStop,
  output logic              txLine,
  output logic              shortCap,
  output logic              extraOnCap,
  output logic              twoStopCap
);

  localparam logic [DATA_W-1:0] FULL_MASK  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] SHORT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] sendMask;
  logic              extraBit;
  logic              parityCalc;

  assign sendMask   = shortWord ? SHORT_MASK : FULL_MASK;
  assign parityCalc = (^(holdReg & sendMask)) ^ parityOdd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobe.holdWr) begin
      holdReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      extraBit   <= 1'b0;
      shortCap   <= 1'b0;
      extraOnCap <= 1'b0;
      twoStopCap <= 1'b0;
    end else if (strobe.loadShift) begin
      shiftReg   <= holdReg;
      extraBit   <= mpMode ? mpBit : parityCalc;
      shortCap   <= shortWord;
      extraOnCap <= mpMode | parityOn;
      twoStopCap <= twoStop;
    end else if (strobe.shiftStep) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    unique case (strobe.lineSel)
      LINE_SPACE: txLine = 1'b0;
      LINE_DATA:  txLine = shiftReg[0];
      LINE_EXTRA: txLine = extraBit;
      default:    txLine = 1'b1;
    endcase
  end

  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lineSel == LINE_EXTRA && !strobe.loadShift) |=> $stable(extraBit));

endmodule

// File: rtl/dbuf_tx_ctrl.sv
module dbuf_tx_ctrl
  import dbuf_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      baudTick,
  input  logic      wrEn,
  input  logic      shortCap,
  input  logic      extraOnCap,
  input  logic      twoStopCap,
  output txStrobe_t strobe,
  output logic      dataEmpty,
  output logic      txEnd
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  txState_e         state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic [CNT_W-1:0] lastIdx;
  logic             loadNow;
  logic             enterFinal;
  logic             emptyQ, endQ;

  assign lastIdx = shortCap ? LAST_SHORT : LAST_LONG;

  always_comb begin
    stateNxt   = state;
    cntNxt     = bitCnt;
    loadNow    = 1'b0;
    enterFinal = 1'b0;
    if (baudTick && txEnable) begin
      unique case (state)
        ST_IDLE: begin
          if (!emptyQ) begin
            loadNow  = 1'b1;
            stateNxt = ST_START;
          end
        end
        ST_START: begin
          stateNxt = ST_DATA;
          cntNxt   = '0;
        end
        ST_DATA: begin
          if (bitCnt == lastIdx) begin
            if (extraOnCap) begin
              stateNxt = ST_EXTRA;
            end else begin
              stateNxt   = ST_STOP1;
              enterFinal = !twoStopCap;
            end
          end else begin
            cntNxt = bitCnt + 1'b1;
          end
        end
        ST_EXTRA: begin
          stateNxt   = ST_STOP1;
          enterFinal = !twoStopCap;
        end
        ST_STOP1: begin
          if (twoStopCap) begin
            stateNxt   = ST_STOP2;
            enterFinal = 1'b1;
          end else if (!emptyQ) begin
            loadNow  = 1'b1;
            stateNxt = ST_START;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
        ST_STOP2: begin
          if (!emptyQ) begin
            loadNow  = 1'b1;
            stateNxt = ST_START;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !txEnable) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      emptyQ <= 1'b1;
      endQ   <= 1'b1;
    end else begin
      state  <= stateNxt;
      bitCnt <= cntNxt;
      if (wrEn) begin
        emptyQ <= 1'b0;
      end else if (loadNow) begin
        emptyQ <= 1'b1;
      end
      if (wrEn) begin
        endQ <= 1'b0;
      end else if (enterFinal && emptyQ) begin
        endQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.holdWr    = wrEn & txEnable;
    strobe.loadShift = loadNow;
    strobe.shiftStep = baudTick & txEnable & (state == ST_DATA);
    unique case (state)
      ST_START: strobe.lineSel = LINE_SPACE;
      ST_DATA:  strobe.lineSel = LINE_DATA;
      ST_EXTRA: strobe.lineSel = LINE_EXTRA;
      default:  strobe.lineSel = LINE_MARK;
    endcase
  end

  assign dataEmpty = emptyQ;
  assign txEnd     = endQ;

  // R3
  start_one_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && baudTick && txEnable) |=> (state == ST_DATA));

  // R2
  write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txEnable) |=> (!dataEmpty && !txEnd));

  // R9
  end_in_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txEnd) && $past(txEnable)) |-> (state == ST_STOP1 || state == ST_STOP2));

  // R7
  second_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP2) |-> twoStopCap);

  // R4
  data_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitCnt <= lastIdx));

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbuf_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              baudTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              shortWord,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              mpMode,
  input  logic              mpBit,
  input  logic              twoStop,
  input  logic              emptyIntEn,
  input  logic              endIntEn,
  output logic              txLine,
  output logic              dataEmpty,
  output logic              txEnd,
  output logic              emptyIrq,
  output logic              endIrq
);

  txStrobe_t strobe;
  logic      shortCap, extraOnCap, twoStopCap;

  dbuf_tx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEnable  (txEnable),
    .baudTick  (baudTick),
    .wrEn      (wrEn),
    .shortCap  (shortCap),
    .extraOnCap(extraOnCap),
    .twoStopCap(twoStopCap),
    .strobe    (strobe),
    .dataEmpty (dataEmpty),
    .txEnd     (txEnd)
  );

  dbuf_tx_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .shortWord (shortWord),
    .parityOn  (parityOn),
    .parityOdd (parityOdd),
    .mpMode    (mpMode),
    .mpBit     (mpBit),
    .twoStop   (twoStop),
    .txLine    (txLine),
    .shortCap  (shortCap),
    .extraOnCap(extraOnCap),
    .twoStopCap(twoStopCap)
  );

  assign emptyIrq = dataEmpty & emptyIntEn;
  assign endIrq   = txEnd & endIntEn;

  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (txLine && dataEmpty && txEnd));

  // R12
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && !baudTick) |=> $stable(txLine));

endmodule

// File: tb/sim_dbuf_serial_tx.sv
module sim_dbuf_serial_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       shortWord = 1'b0;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       mpMode = 1'b0;
  logic       mpBit = 1'b0;
  logic       twoStop = 1'b0;
  logic       emptyIntEn = 1'b0;
  logic       endIntEn = 1'b0;
  logic       txLine, dataEmpty, txEnd, emptyIrq, endIrq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dbuf_serial_tx u0 (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .baudTick(baudTick),
    .wrEn(wrEn), .wrData(wrData), .shortWord(shortWord), .parityOn(parityOn),
    .parityOdd(parityOdd), .mpMode(mpMode), .mpBit(mpBit), .twoStop(twoStop),
    .emptyIntEn(emptyIntEn), .endIntEn(endIntEn), .txLine(txLine),
    .dataEmpty(dataEmpty), .txEnd(txEnd), .emptyIrq(emptyIrq), .endIrq(endIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expParity(input logic [7:0] d, input logic s7, input logic odd);
    logic [7:0] m;
    m = s7 ? (d & 8'h7f) : d;
    return (^m) ^ odd;
  endfunction

  task automatic tick();
    @(negedge clk) baudTick = 1'b1;
    @(negedge clk) baudTick = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk) begin wrEn = 1'b1; wrData = d; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  // Runs one frame already written; start tick included unless started=1.
  task automatic runFrame(input logic [7:0] d, input bit started, input bit pend,
                          input logic [7:0] nd, input bit capMp);
    int nData;
    if (!started) begin
      tick();
      check(txLine == 1'b0, "R3 start bit", txLine, 0);
      check(dataEmpty == 1'b1, "R2 empty after load", dataEmpty, 1);
    end
    if (capMp) mpBit = ~mpBit;
    if (pend) writeByte(nd);
    nData = shortWord ? 7 : 8;
    for (int i = 0; i < nData; i++) begin
      tick();
      check(txLine == d[i], "R4 data bit", txLine, d[i]);
    end
    if (mpMode) begin
      tick();
      check(txLine == (capMp ? ~mpBit : mpBit), "R6 mp bit", txLine, capMp ? ~mpBit : mpBit);
    end else if (parityOn) begin
      tick();
      check(txLine == expParity(d, shortWord, parityOdd), "R5 parity", txLine,
            expParity(d, shortWord, parityOdd));
    end
    for (int s = 0; s < (twoStop ? 2 : 1); s++) begin
      tick();
      check(txLine == 1'b1, "R7 stop bit", txLine, 1);
      if (s == (twoStop ? 1 : 0))
        check(txEnd == !pend, "R9 end flag in final stop", txEnd, !pend);
      else
        check(txEnd == 1'b0, "R9 end flag early", txEnd, 0);
    end
    if (capMp) mpBit = ~mpBit;
    tick();
    if (pend) begin
      check(txLine == 1'b0, "R8 chained start", txLine, 0);
      check(dataEmpty == 1'b1, "R8 chained load", dataEmpty, 1);
    end else begin
      check(txLine == 1'b1 && txEnd == 1'b1, "R9 idle after stop", txLine, 1);
      tick();
      check(txLine == 1'b1, "R9 line stays marked", txLine, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine && dataEmpty && txEnd, "R1 reset state", {txLine, dataEmpty, txEnd}, 7);
    txEnable = 1'b1;
    @(negedge clk);
    check(txLine && dataEmpty && txEnd, "R1 enabled idle", {txLine, dataEmpty, txEnd}, 7);

    // R10 interrupt gating
    emptyIntEn = 1'b1; endIntEn = 1'b0;
    @(negedge clk);
    check(emptyIrq == 1'b1 && endIrq == 1'b0, "R10 irq gating", {emptyIrq, endIrq}, 2);
    endIntEn = 1'b1;

    // R2 write clears flags
    writeByte(8'hA5);
    check(!dataEmpty && !txEnd, "R2 write clears flags", {dataEmpty, txEnd}, 0);
    check(emptyIrq == 1'b0 && endIrq == 1'b0, "R10 irq follows flags", {emptyIrq, endIrq}, 0);
    runFrame(8'hA5, 1'b0, 1'b0, 8'h00, 1'b0);
    check(endIrq == 1'b1, "R10 end irq", endIrq, 1);

    // R12 no change without tick
    writeByte(8'h3C);
    tick();
    repeat (6) @(negedge clk);
    check(txLine == 1'b0, "R12 start held without tick", txLine, 0);
    runFrame(8'h3C, 1'b1, 1'b0, 8'h00, 1'b0);

    // R8 chained frames, 7-bit odd parity two stops
    shortWord = 1'b1; parityOn = 1'b1; parityOdd = 1'b1; twoStop = 1'b1;
    writeByte(8'hF1);
    runFrame(8'hF1, 1'b0, 1'b1, 8'h96, 1'b0);
    runFrame(8'h96, 1'b1, 1'b0, 8'h00, 1'b0);

    // R6 multiprocessor bit captured at load, overrides parity
    shortWord = 1'b0; mpMode = 1'b1; mpBit = 1'b1; twoStop = 1'b0;
    writeByte(8'h5E);
    runFrame(8'h5E, 1'b0, 1'b0, 8'h00, 1'b1);
    mpMode = 1'b0; parityOn = 1'b0;

    // R11 disabled: writes ignored
    txEnable = 1'b0;
    writeByte(8'h00);
    check(txLine && dataEmpty && txEnd, "R11 disabled flags", {txLine, dataEmpty, txEnd}, 7);
    tick();
    check(txLine == 1'b1, "R11 disabled line", txLine, 1);
    txEnable = 1'b1;
    tick();
    tick();
    check(txLine == 1'b1 && dataEmpty == 1'b1, "R11 write ignored", {txLine, dataEmpty}, 3);

    // Random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      shortWord = 1'($urandom);
      parityOn  = 1'($urandom);
      parityOdd = 1'($urandom);
      mpMode    = 1'($urandom);
      mpBit     = 1'($urandom);
      twoStop   = 1'($urandom);
      writeByte(d);
      runFrame(d, 1'b0, 1'b0, 8'h00, 1'($urandom));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule